// File: doc/BRIEF.md
# Per-Die Status Word and Bus Output Selector

This block keeps the eight-bit status word of one flash die and decides what the die places on its shared data bus during a read cycle. The operation engine supplies its busy flags, the pass or fail results of the current and previous operations, and the error classification of a page read. The write-protect pin also feeds in. The block puts these together into a status word whose bit meanings depend on the class of operation in progress.

A status-read command from the command decoder switches the die into status output mode. Any other command switches it back to array data. The mode is sticky. While chip enable and read enable are both held low, the bus follows the status word as it changes, so the host needs no further read-enable edge to see an update. The ready/busy output is taken from the cache-ready bit of the same word.

Top module: `die_status_port`

## Requirements
- R1: After reset, status output mode is off, so a read cycle (ce_n=0, re_n=0) drives array_data onto dq_out.
- R2: A command cycle (cmd_valid=1) with code STATUS_CMD (default 8'h70) turns status output mode on. From the next clock, a read cycle drives the status word on dq_out[7:0], and any higher bits are zero.
- R3: A command cycle with any code other than STATUS_CMD, 8'h00 included, turns status output mode off. From the next clock, a read cycle drives array_data.
- R4: In status output mode with ce_n and re_n held low, a change on any engine input appears on dq_out one clock later, with no edge on re_n.
- R5: Status bit 7 equals wp_n: 0 means protected, 1 means not protected.
- R6: For op_kind codes 0 (page read), 2 (program), 4 (erase) and the unused codes 5 to 7, bits 6 and 5 are both ~array_busy.
- R7: For op_kind codes 1 (cache read) and 3 (cache program), bit 6 is ~cache_busy and bit 5 is ~array_busy.
- R8: Bit 0 is fail_cur for codes 2, 3 and 4. It is ecc_uncorr for code 0, and 0 for all other codes.
- R9: Bit 1 is fail_prev for code 3 only, and 0 for all other codes.
- R10: Bit 3 is ecc_rewrite for code 0 only, and 0 otherwise. Bits 4 and 2 are always 0.
- R11: rb_n equals status bit 6 one clock after the inputs are applied.
- R12: dq_oe is 1 only when ce_n and re_n are both 0. In every other case dq_oe is 0 and dq_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | One-cycle strobe for a latched command |
| cmd_code | input | 8 | Command code that goes with cmd_valid |
| op_kind | input | 3 | Class of the current operation (0 to 4 as in R6 to R10) |
| array_busy | input | 1 | An internal array operation is running |
| cache_busy | input | 1 | The cache register cannot accept new data |
| fail_cur | input | 1 | The current program or erase failed |
| fail_prev | input | 1 | The previous cache program failed |
| ecc_rewrite | input | 1 | The page read was corrected and a rewrite is advised |
| ecc_uncorr | input | 1 | The page read has an uncorrectable error |
| wp_n | input | 1 | Write-protect pin level |
| ce_n | input | 1 | Chip enable, active low |
| re_n | input | 1 | Read enable, active low |
| array_data | input | DATA_W | Data from the cache register |
| dq_out | output | DATA_W | Value driven onto the data bus |
| dq_oe | output | 1 | Bus output enable |
| rb_n | output | 1 | Ready/busy indication |

## Verification
The case that is hardest to reach from the ports is a status word that changes while a read cycle is already open. The bench must hold ce_n and re_n low across several clocks and change only the engine flags. It does this during the live-update test, and also during a full sweep of all eight op_kind codes against all 128 combinations of the seven engine flags. Each of those results is predicted bit by bit from the requirement text. Mode switching is checked by putting status-read, read-mode and unrelated command codes between reads of array data.

// File: rtl/die_status_pkg.sv
package die_status_pkg;

  localparam int SR_W = 8;

  // bit positions inside the status word
  localparam int SB_WP    = 7;
  localparam int SB_CRDY  = 6;
  localparam int SB_ARDY  = 5;
  localparam int SB_REWR  = 3;
  localparam int SB_PFAIL = 1;
  localparam int SB_FAIL  = 0;

  typedef enum logic [2:0] {
    OP_PAGE_READ     = 3'd0,
    OP_CACHE_READ    = 3'd1,
    OP_PROGRAM       = 3'd2,
    OP_CACHE_PROGRAM = 3'd3,
    OP_ERASE         = 3'd4
  } op_kind_e;

  typedef struct packed {
    logic wp_n;
    logic array_busy;
    logic cache_busy;
    logic fail_cur;
    logic fail_prev;
    logic ecc_rewrite;
    logic ecc_uncorr;
  } engine_flags_t;

endpackage

// File: rtl/status_assembler.sv
module status_assembler
  import die_status_pkg::*;
(
  input  logic [2:0]      op_kind,
  input  engine_flags_t   flags,
  output logic [SR_W-1:0] sr_word
);

  op_kind_e op;

  always_comb begin
    op      = op_kind_e'(op_kind);
    sr_word = '0;
    sr_word[SB_WP] = flags.wp_n;
    // ready bits: cache classes split the two readiness levels
    case (op)
      OP_CACHE_READ, OP_CACHE_PROGRAM: begin
        sr_word[SB_CRDY] = ~flags.cache_busy;
        sr_word[SB_ARDY] = ~flags.array_busy;
      end
      default: begin
        sr_word[SB_CRDY] = ~flags.array_busy;
        sr_word[SB_ARDY] = ~flags.array_busy;
      end
    endcase
    // result bits: meaning depends on operation class
    case (op)
      OP_PAGE_READ: begin
        sr_word[SB_REWR] = flags.ecc_rewrite;
        sr_word[SB_FAIL] = flags.ecc_uncorr;
      end
      OP_PROGRAM, OP_ERASE: begin
        sr_word[SB_FAIL] = flags.fail_cur;
      end
      OP_CACHE_PROGRAM: begin
        sr_word[SB_FAIL]  = flags.fail_cur;
        sr_word[SB_PFAIL] = flags.fail_prev;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/status_mode_ctl.sv
module status_mode_ctl #(
  parameter logic [7:0] STATUS_CMD = 8'h70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       sr_mode
);

  logic mode_d;
  logic mode_q;

  always_comb begin
    mode_d = mode_q;
    if (cmd_valid) begin
      mode_d = (cmd_code == STATUS_CMD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (cmd_valid) begin
      mode_q <= mode_d;
    end
  end

  assign sr_mode = mode_q;

endmodule

// File: rtl/status_bus_mux.sv
module status_bus_mux
  import die_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              sr_mode,
  input  logic [SR_W-1:0]   sr_word,
  input  logic [DATA_W-1:0] array_data,
  input  logic              ce_n,
  input  logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int PAD_W = DATA_W - SR_W;

  logic [DATA_W-1:0] sr_ext;
  logic              drive;

  generate
    if (PAD_W > 0) begin : g_pad
      assign sr_ext = {{PAD_W{1'b0}}, sr_word};
    end else begin : g_nopad
      assign sr_ext = sr_word[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    drive  = ~ce_n & ~re_n;
    dq_oe  = drive;
    dq_out = '0;
    if (drive) begin
      dq_out = sr_mode ? sr_ext : array_data;
    end
  end

endmodule

// File: rtl/die_status_port.sv
module die_status_port
  import die_status_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [7:0] STATUS_CMD = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [2:0]        op_kind,
  input  logic              array_busy,
  input  logic              cache_busy,
  input  logic              fail_cur,
  input  logic              fail_prev,
  input  logic              ecc_rewrite,
  input  logic              ecc_uncorr,
  input  logic              wp_n,
  input  logic              ce_n,
  input  logic              re_n,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rb_n
);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  engine_flags_t   flags;
  logic [SR_W-1:0] sr_next;
  logic [SR_W-1:0] sr_q;
  logic            sr_mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign flags = '{wp_n:        wp_n,
                   array_busy:  array_busy,
                   cache_busy:  cache_busy,
                   fail_cur:    fail_cur,
                   fail_prev:   fail_prev,
                   ecc_rewrite: ecc_rewrite,
                   ecc_uncorr:  ecc_uncorr};

  status_assembler u_asm (
    .op_kind (op_kind),
    .flags   (flags),
    .sr_word (sr_next)
  );

  // status word refreshed every cycle so the bus follows it live
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_next;
    end
  end

  status_mode_ctl #(.STATUS_CMD(STATUS_CMD)) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .sr_mode   (sr_mode)
  );

  status_bus_mux #(.DATA_W(DATA_W)) u_mux (
    .sr_mode    (sr_mode),
    .sr_word    (sr_q),
    .array_data (array_data),
    .ce_n       (ce_n),
    .re_n       (re_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  assign rb_n = sr_q[SB_CRDY];

endmodule

// File: rtl/die_status_port_chk.sv
module die_status_port_chk
  import die_status_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [7:0] STATUS_CMD = 8'h70
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic [2:0]        op_kind,
  input logic              array_busy,
  input logic              cache_busy,
  input logic              wp_n,
  input logic              ce_n,
  input logic              re_n,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              rb_n
);

  // R2 R5
  wp_after_status_cmd_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_code == STATUS_CMD) |=> (ce_n || re_n || dq_out[SB_WP] == $past(wp_n)));

  // R3
  array_after_other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_code != STATUS_CMD) |=> (ce_n || re_n || dq_out == array_data));

  // R7 R11
  cache_ready_rb_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ((op_kind == OP_CACHE_READ || op_kind == OP_CACHE_PROGRAM) && !cache_busy) |=> rb_n);

  // R6 R11
  array_busy_rb_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!(op_kind == OP_CACHE_READ || op_kind == OP_CACHE_PROGRAM) && array_busy) |=> !rb_n);

  // R12
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ce_n || re_n) |-> (!dq_oe && dq_out == '0));

endmodule

bind die_status_port die_status_port_chk #(.DATA_W(DATA_W), .STATUS_CMD(STATUS_CMD)) chk_i (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .op_kind    (op_kind),
  .array_busy (array_busy),
  .cache_busy (cache_busy),
  .wp_n       (wp_n),
  .ce_n       (ce_n),
  .re_n       (re_n),
  .array_data (array_data),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .rb_n       (rb_n)
);

// File: tb/die_status_port_tb.sv
module die_status_port_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [7:0]    cmd_code;
  logic [2:0]    op_kind;
  logic          array_busy, cache_busy, fail_cur, fail_prev;
  logic          ecc_rewrite, ecc_uncorr, wp_n, ce_n, re_n;
  logic [DW-1:0] array_data;
  logic [DW-1:0] dq_out;
  logic          dq_oe, rb_n;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  die_status_port #(.DATA_W(DW), .STATUS_CMD(8'h70)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .op_kind(op_kind), .array_busy(array_busy), .cache_busy(cache_busy),
    .fail_cur(fail_cur), .fail_prev(fail_prev), .ecc_rewrite(ecc_rewrite),
    .ecc_uncorr(ecc_uncorr), .wp_n(wp_n), .ce_n(ce_n), .re_n(re_n),
    .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe), .rb_n(rb_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status word, built field by field from the requirements
  function automatic logic [7:0] expect_sr(input int op, input logic [6:0] v);
    logic [7:0] s;
    bit cache_cls;
    s = 8'h00;
    cache_cls = (op == 1 || op == 3);
    s[7] = v[0];
    s[6] = cache_cls ? !v[2] : !v[1];
    s[5] = !v[1];
    if (op == 0) begin s[3] = v[5]; s[0] = v[6]; end
    if (op == 2 || op == 4) s[0] = v[3];
    if (op == 3) begin s[0] = v[3]; s[1] = v[4]; end
    return s;
  endfunction

  task automatic set_flags(input int op, input logic [6:0] v);
    op_kind     = op[2:0];
    wp_n        = v[0];
    array_busy  = v[1];
    cache_busy  = v[2];
    fail_cur    = v[3];
    fail_prev   = v[4];
    ecc_rewrite = v[5];
    ecc_uncorr  = v[6];
  endtask

  task automatic send_cmd(input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 8'hFF;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 8'hFF;
    ce_n = 1'b1; re_n = 1'b1; array_data = 8'h5A;
    set_flags(2, 7'b0000001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 idle bus, R1 array data after reset
    check("R12 oe idle", {15'd0, dq_oe}, 16'd0);
    check("R12 dq idle", {8'd0, dq_out}, 16'd0);
    ce_n = 1'b0; re_n = 1'b0;
    #1;
    check("R1 reset mode", {8'd0, dq_out}, 16'h5A);
    check("R12 oe read", {15'd0, dq_oe}, 16'd1);

    // R2 status on
    send_cmd(8'h70);
    check("R2 status on", {8'd0, dq_out}, {8'd0, expect_sr(2, 7'b0000001)});

    // R5..R11 sweep: every class with every flag pattern
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 128; v++) begin
        logic [7:0] e;
        @(negedge clk);
        set_flags(op, v[6:0]);
        @(negedge clk);
        e = expect_sr(op, v[6:0]);
        check("R5 wp bit", {15'd0, dq_out[7]}, {15'd0, e[7]});
        if (op == 1 || op == 3)
          check("R7 ready bits", {14'd0, dq_out[6:5]}, {14'd0, e[6:5]});
        else
          check("R6 ready bits", {14'd0, dq_out[6:5]}, {14'd0, e[6:5]});
        check("R8 fail bit", {15'd0, dq_out[0]}, {15'd0, e[0]});
        check("R9 prev fail bit", {15'd0, dq_out[1]}, {15'd0, e[1]});
        check("R10 bits 4,3,2", {13'd0, dq_out[4:2]}, {13'd0, e[4:2]});
        check("R11 rb_n", {15'd0, rb_n}, {15'd0, e[6]});
      end
    end

    // R4 live update with re_n held low
    @(negedge clk);
    set_flags(3, 7'b0000111);
    @(negedge clk);
    check("R4 live busy", {8'd0, dq_out}, {8'd0, expect_sr(3, 7'b0000111)});
    cache_busy = 1'b0;
    @(negedge clk);
    check("R4 live cache ready", {8'd0, dq_out}, {8'd0, expect_sr(3, 7'b0000011)});
    array_busy = 1'b0; fail_prev = 1'b1;
    @(negedge clk);
    check("R4 live done", {8'd0, dq_out}, {8'd0, expect_sr(3, 7'b0010001)});

    // R12 gating while in status mode
    re_n = 1'b1;
    #1;
    check("R12 re high", {7'd0, dq_oe, dq_out}, 16'd0);
    re_n = 1'b0; ce_n = 1'b1;
    #1;
    check("R12 ce high", {7'd0, dq_oe, dq_out}, 16'd0);
    ce_n = 1'b0;

    // R3 read-mode command and other commands
    send_cmd(8'h00);
    array_data = 8'hC3;
    #1;
    check("R3 read mode 00", {8'd0, dq_out}, 16'hC3);
    send_cmd(8'h70);
    check("R2 status again", {8'd0, dq_out}, {8'd0, expect_sr(3, 7'b0010001)});
    send_cmd(8'h05);
    check("R3 other cmd", {8'd0, dq_out}, 16'hC3);
    send_cmd(8'h71);
    check("R3 near code", {8'd0, dq_out}, 16'hC3);
    send_cmd(8'h70);
    send_cmd(8'h70);
    check("R2 repeat cmd", {8'd0, dq_out}, {8'd0, expect_sr(3, 7'b0010001)});

    // R1 reset clears the mode
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 mode after reset", {8'd0, dq_out}, 16'hC3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule